// File: doc/BRIEF.md
# Nine-Bit Serial Port with Address Filtering

This block is a full-duplex asynchronous serial port whose frames carry eight data bits plus a ninth, software-chosen bit. A host writes a byte to start sending it, and reads the last accepted byte and its ninth bit on the receive side. Each direction has a completion flag that only software clears, and a single interrupt line reports either flag while interrupts are enabled.

Bit timing comes from an external tick that pulses at sixteen times the bit rate. The receiver oversamples the line and votes over three samples near each bit centre. A receive filter drops frames while the previous byte is still unread. In multiprocessor mode it also drops every frame whose ninth bit is 0. A network of nodes can use this to wake only on address frames.

Top module: `uart9_port`

## Requirements
- R1: After reset and whenever no frame is being sent, `txd` is 1. After reset both flags, `irq` and `rx_data` are 0.
- R2: A `tx_wr` pulse while idle sends one 11-bit frame on `txd`. The frame is a 0 start bit, then `tx_data` least significant bit first, then the value of `tx_bit9` at the write, then a 1 stop bit. Each bit lasts 16 `baud_tick` pulses.
- R3: `tx_flag` goes to 1 at the first clock of the stop bit, 160 ticks after the write edge, and not before.
- R4: A `tx_wr` pulse during a transmission is ignored, and the frame in flight goes out unchanged.
- R5: With `rx_en`=1 and `rx_flag`=0, a well-formed frame on `rxd` loads its eight data bits into `rx_data` and its ninth bit into `rx_bit9`, and sets `rx_flag`.
- R6: While `rx_en`=0, start bits on `rxd` are ignored, and `rx_flag`, `rx_data` and `rx_bit9` keep their values.
- R7: A frame that completes while `rx_flag`=1 is discarded, and `rx_data`, `rx_bit9` and `rx_flag` stay unchanged.
- R8: With `mp_en`=1, a frame whose ninth bit is 0 is discarded with no state change, and a frame whose ninth bit is 1 is accepted.
- R9: The received stop bit level is not checked. A frame whose stop bit is 0 is still accepted.
- R10: A low pulse on `rxd` that reads high in the majority of the samples at ticks 7, 8 and 9 after its detection is a false start. It is dropped, and it does not disturb the next frame.
- R11: `tx_flag` and `rx_flag` stay at 1 until a one-cycle pulse on `tx_flag_clr` or `rx_flag_clr` returns them to 0.
- R12: `irq` is 1 exactly when `irq_en` is 1 and at least one of the two flags is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| tx_wr | input | 1 | Write strobe that starts a transmission |
| tx_data | input | 8 | Byte to send |
| tx_bit9 | input | 1 | Ninth bit to send |
| rx_en | input | 1 | Receive enable |
| mp_en | input | 1 | Multiprocessor (address-filter) mode |
| irq_en | input | 1 | Interrupt enable |
| tx_flag_clr | input | 1 | Clears the transmit flag |
| rx_flag_clr | input | 1 | Clears the receive flag |
| rxd | input | 1 | Serial input, idle high |
| txd | output | 1 | Serial output, idle high |
| rx_data | output | 8 | Last accepted byte |
| rx_bit9 | output | 1 | Ninth bit of the last accepted frame |
| tx_flag | output | 1 | Transmit-complete flag |
| rx_flag | output | 1 | Receive-complete flag |
| irq | output | 1 | Combined interrupt |

## Verification
The embedded properties assume a few things about the inputs. Flag-clear pulses do not land on the same cycle as a frame completion. `mp_en` is steady while a frame is being accepted. `rxd` changes only on whole bit periods, apart from deliberately short glitches. The bench holds `baud_tick` high so that one bit is sixteen clocks. It changes `rx_en`, `mp_en` and `irq_en` only while the line is idle, and it clears each flag only after a frame has fully ended. The false-start glitches last 5 and 8 clocks. Both are short enough that at most one of the three votes reads low.

// File: rtl/uart9_pkg.sv
package uart9_pkg;

   typedef enum logic {
      TX_IDLE = 1'b0,
      TX_SEND = 1'b1
   } tx_state_e;

   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/uart9_sync.sv
module uart9_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("uart9_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] chain;

   if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= d;
      end
   end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[STAGES-2:0], d};
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/uart9_tx.sv
module uart9_tx
   import uart9_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr,
   input  logic [DATA_W-1:0] data,
   input  logic              bit9,
   input  logic              flag_clr,
   output logic              txd,
   output logic              flag
);
   localparam int FRAME_BITS = DATA_W + 3;
   localparam int STOP_IDX   = FRAME_BITS - 1;
   localparam int IDX_W      = $clog2(FRAME_BITS);
   localparam int CNT_W      = $clog2(OVS);

   if (OVS < 4) begin : g_bad_ovs
      $error("uart9_tx: OVS must be at least 4");
   end

   tx_state_e             st;
   logic [FRAME_BITS-1:0] sh;
   logic [IDX_W-1:0]      idx;
   logic [CNT_W-1:0]      cnt;
   logic                  txd_q;
   logic                  flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= TX_IDLE;
         sh     <= '1;
         idx    <= '0;
         cnt    <= '0;
         txd_q  <= 1'b1;
         flag_q <= 1'b0;
      end else begin
         if (flag_clr) flag_q <= 1'b0;
         case (st)
            TX_IDLE: begin
               if (wr) begin
                  sh    <= {1'b1, bit9, data, 1'b0};
                  txd_q <= 1'b0;
                  idx   <= '0;
                  cnt   <= '0;
                  st    <= TX_SEND;
               end
            end
            TX_SEND: begin
               if (tick) begin
                  if (cnt == CNT_W'(OVS - 1)) begin
                     cnt <= '0;
                     if (idx == IDX_W'(STOP_IDX)) begin
                        st    <= TX_IDLE;
                        txd_q <= 1'b1;
                     end else begin
                        idx   <= idx + 1'b1;
                        sh    <= {1'b1, sh[FRAME_BITS-1:1]};
                        txd_q <= sh[1];
                        if (idx == IDX_W'(STOP_IDX - 1)) flag_q <= 1'b1;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            default: st <= TX_IDLE;
         endcase
      end
   end

   assign txd  = txd_q;
   assign flag = flag_q;

   p_txd_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == TX_IDLE) |-> txd_q);

   p_flag_at_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> (idx == IDX_W'(STOP_IDX)));

   p_busy_write_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == TX_SEND && wr && idx != '0) |=> (idx != '0));
endmodule

// File: rtl/uart9_rx.sv
module uart9_rx
   import uart9_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16,
   parameter bit VOTE3  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rxs,
   input  logic              rx_en,
   input  logic              mp_en,
   input  logic              flag_clr,
   output logic [DATA_W-1:0] data,
   output logic              bit9,
   output logic              flag
);
   localparam int FRAME_BITS = DATA_W + 3;
   localparam int STOP_IDX   = FRAME_BITS - 1;
   localparam int IDX_W      = $clog2(FRAME_BITS);
   localparam int CNT_W      = $clog2(OVS);
   localparam int MID        = OVS / 2;

   if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("uart9_rx: OVS must be even and at least 4");
   end

   logic              busy;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  nxt;
   logic [IDX_W-1:0]  idx;
   logic [1:0]        vs;
   logic [DATA_W:0]   sh;
   logic [DATA_W-1:0] data_q;
   logic              b9_q;
   logic              flag_q;
   logic              bit_val;
   logic              accept;

   assign nxt = cnt + 1'b1;

   if (VOTE3) begin : g_vote3
      assign bit_val = maj3(vs[0], vs[1], rxs);
   end else begin : g_vote1
      assign bit_val = vs[1];
   end

   assign accept = !flag_q && (!mp_en || sh[DATA_W]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         cnt    <= '0;
         idx    <= '0;
         vs     <= '1;
         sh     <= '0;
         data_q <= '0;
         b9_q   <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         if (flag_clr) flag_q <= 1'b0;
         if (!busy) begin
            if (tick && rx_en && !rxs) begin
               busy <= 1'b1;
               cnt  <= '0;
               idx  <= '0;
            end
         end else if (tick) begin
            if (cnt == CNT_W'(OVS - 1)) begin
               cnt <= '0;
               idx <= idx + 1'b1;
            end else begin
               cnt <= nxt;
            end
            if (nxt == CNT_W'(MID - 1)) vs[0] <= rxs;
            if (nxt == CNT_W'(MID))     vs[1] <= rxs;
            if (nxt == CNT_W'(MID + 1)) begin
               if (idx == '0) begin
                  if (bit_val) busy <= 1'b0;
               end else if (idx == IDX_W'(STOP_IDX)) begin
                  busy <= 1'b0;
                  if (accept) begin
                     data_q <= sh[DATA_W-1:0];
                     b9_q   <= sh[DATA_W];
                     flag_q <= 1'b1;
                  end
               end else begin
                  sh <= {bit_val, sh[DATA_W:1]};
               end
            end
         end
      end
   end

   assign data = data_q;
   assign bit9 = b9_q;
   assign flag = flag_q;

   p_disabled_stays_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !rx_en) |=> !busy);

   p_full_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !flag_clr) |=> (flag_q && $stable(data_q) && $stable(b9_q)));

   p_mp_needs_address_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(flag_q) && $past(mp_en)) |-> b9_q);

   p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !flag_clr) |=> flag_q);
endmodule

// File: rtl/uart9_port.sv
module uart9_port #(
   parameter int DATA_W      = 8,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit VOTE3       = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              tx_wr,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_bit9,
   input  logic              rx_en,
   input  logic              mp_en,
   input  logic              irq_en,
   input  logic              tx_flag_clr,
   input  logic              rx_flag_clr,
   input  logic              rxd,
   output logic              txd,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_bit9,
   output logic              tx_flag,
   output logic              rx_flag,
   output logic              irq
);
   if (DATA_W < 1) begin : g_bad_width
      $error("uart9_port: DATA_W must be positive");
   end

   logic rx_sync;

   uart9_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rxd),
      .q     (rx_sync)
   );

   uart9_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (baud_tick),
      .wr       (tx_wr),
      .data     (tx_data),
      .bit9     (tx_bit9),
      .flag_clr (tx_flag_clr),
      .txd      (txd),
      .flag     (tx_flag)
   );

   uart9_rx #(.DATA_W(DATA_W), .OVS(OVS), .VOTE3(VOTE3)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (baud_tick),
      .rxs      (rx_sync),
      .rx_en    (rx_en),
      .mp_en    (mp_en),
      .flag_clr (rx_flag_clr),
      .data     (rx_data),
      .bit9     (rx_bit9),
      .flag     (rx_flag)
   );

   assign irq = irq_en & (tx_flag | rx_flag);

   p_irq_masked_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq);
endmodule

// File: tb/uart9_port_bench.sv
module uart9_port_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b1;
   logic       tx_wr = 1'b0;
   logic [7:0] tx_data = 8'h00;
   logic       tx_bit9 = 1'b0;
   logic       rx_en = 1'b0;
   logic       mp_en = 1'b0;
   logic       irq_en = 1'b0;
   logic       tx_flag_clr = 1'b0;
   logic       rx_flag_clr = 1'b0;
   logic       rxd = 1'b1;
   logic       txd;
   logic [7:0] rx_data;
   logic       rx_bit9;
   logic       tx_flag;
   logic       rx_flag;
   logic       irq;

   int checks = 0;
   int failures = 0;
   logic [7:0] exp_data = 8'h00;
   logic       exp_b9 = 1'b0;

   always #4 clk = ~clk;

   uart9_port u_uart9_port (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_wr(tx_wr),
      .tx_data(tx_data), .tx_bit9(tx_bit9), .rx_en(rx_en), .mp_en(mp_en),
      .irq_en(irq_en), .tx_flag_clr(tx_flag_clr), .rx_flag_clr(rx_flag_clr),
      .rxd(rxd), .txd(txd), .rx_data(rx_data), .rx_bit9(rx_bit9),
      .tx_flag(tx_flag), .rx_flag(rx_flag), .irq(irq)
   );

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic report;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   // sends one frame and checks every bit centre, the flag edge and the idle level
   task automatic tx_frame(input logic [7:0] d, input logic b9, input logic poke);
      logic exp_bit;
      @(negedge clk);
      tx_data = d; tx_bit9 = b9; tx_wr = 1'b1;
      @(negedge clk);
      tx_wr = 1'b0; tx_data = ~d; tx_bit9 = ~b9;
      for (int n = 1; n <= 184; n++) begin
         if (n > 1) @(negedge clk);
         if (poke && n == 40) begin tx_wr = 1'b1; tx_data = ~d; end
         if (poke && n == 41) tx_wr = 1'b0;
         if (n >= 8 && n <= 168 && ((n - 8) % 16) == 0) begin
            int k;
            k = (n - 8) / 16;
            if (k == 0)       exp_bit = 1'b0;
            else if (k <= 8)  exp_bit = d[k-1];
            else if (k == 9)  exp_bit = b9;
            else              exp_bit = 1'b1;
            chk(txd === exp_bit, poke ? "R4 frame kept despite busy write" : "R2 txd bit",
                int'(txd), int'(exp_bit));
         end
         if (n == 160) chk(tx_flag === 1'b0, "R3 tx_flag early", int'(tx_flag), 0);
         if (n == 161) chk(tx_flag === 1'b1, "R3 tx_flag at stop start", int'(tx_flag), 1);
      end
      chk(txd === 1'b1, "R1 txd idle after frame", int'(txd), 1);
      chk(irq === irq_en, "R12 irq with tx_flag", int'(irq), int'(irq_en));
      tx_flag_clr = 1'b1;
      @(negedge clk);
      tx_flag_clr = 1'b0;
      chk(tx_flag === 1'b0, "R11 tx_flag cleared", int'(tx_flag), 0);
   endtask

   task automatic rx_frame(input logic [7:0] d, input logic b9, input logic stop_lvl);
      for (int k = 0; k < 11; k++) begin
         if (k == 0)      rxd = 1'b0;
         else if (k <= 8) rxd = d[k-1];
         else if (k == 9) rxd = b9;
         else             rxd = stop_lvl;
         repeat (16) @(negedge clk);
      end
      rxd = 1'b1;
      repeat (30) @(negedge clk);
   endtask

   task automatic rx_expect(input logic fl, input string tag);
      chk(rx_flag === fl, tag, int'(rx_flag), int'(fl));
      chk(rx_data === exp_data, tag, int'(rx_data), int'(exp_data));
      chk(rx_bit9 === exp_b9, tag, int'(rx_bit9), int'(exp_b9));
   endtask

   task automatic rx_clear;
      rx_flag_clr = 1'b1;
      @(negedge clk);
      rx_flag_clr = 1'b0;
      chk(rx_flag === 1'b0, "R11 rx_flag cleared", int'(rx_flag), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      report();
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(txd === 1'b1, "R1 reset txd", int'(txd), 1);
      chk(tx_flag === 1'b0, "R1 reset tx_flag", int'(tx_flag), 0);
      chk(rx_flag === 1'b0, "R1 reset rx_flag", int'(rx_flag), 0);
      chk(irq === 1'b0, "R1 reset irq", int'(irq), 0);
      chk(rx_data === 8'h00, "R1 reset rx_data", int'(rx_data), 0);

      // transmit sweep
      for (int i = 0; i < 38; i++) begin
         logic [7:0] v;
         v = (i == 37) ? 8'hFF : 8'(i * 7);
         irq_en = i[0];
         tx_frame(v, v[0] ^ v[7], 1'b0);
      end
      irq_en = 1'b1;
      tx_frame(8'hA5, 1'b1, 1'b1);
      tx_frame(8'h5A, 1'b0, 1'b0);

      // transmit flag persists
      tx_frame(8'h3C, 1'b1, 1'b0);

      // receive sweep over every byte
      rx_en = 1'b1;
      for (int v = 0; v < 256; v++) begin
         exp_data = 8'(v); exp_b9 = ^exp_data;
         rx_frame(exp_data, exp_b9, 1'b1);
         rx_expect(1'b1, "R5 received frame");
         chk(irq === 1'b1, "R12 irq with rx_flag", int'(irq), 1);
         rx_clear();
      end

      // R11 and R7: flag held, next frame discarded
      exp_data = 8'h42; exp_b9 = 1'b1;
      rx_frame(8'h42, 1'b1, 1'b1);
      repeat (300) @(negedge clk);
      rx_expect(1'b1, "R11 rx_flag persists");
      rx_frame(8'hBD, 1'b0, 1'b1);
      rx_expect(1'b1, "R7 frame dropped while full");
      irq_en = 1'b0;
      @(negedge clk);
      chk(irq === 1'b0, "R12 irq masked", int'(irq), 0);
      irq_en = 1'b1;
      rx_clear();

      // R8 multiprocessor filtering
      mp_en = 1'b1;
      rx_frame(8'h5A, 1'b0, 1'b1);
      rx_expect(1'b0, "R8 data frame dropped in mp mode");
      exp_data = 8'h3C; exp_b9 = 1'b1;
      rx_frame(8'h3C, 1'b1, 1'b1);
      rx_expect(1'b1, "R8 address frame accepted");
      rx_clear();
      mp_en = 1'b0;

      // R6 receiver disabled
      rx_en = 1'b0;
      rx_frame(8'h11, 1'b1, 1'b1);
      rx_expect(1'b0, "R6 frame ignored while disabled");
      rx_en = 1'b1;

      // R9 stop bit low still accepted
      exp_data = 8'h77; exp_b9 = 1'b1;
      rx_frame(8'h77, 1'b1, 1'b0);
      rx_expect(1'b1, "R9 low stop bit accepted");
      rx_clear();

      // R10 false starts of 5 and 8 clocks
      rxd = 1'b0; repeat (5) @(negedge clk); rxd = 1'b1;
      repeat (40) @(negedge clk);
      rx_expect(1'b0, "R10 short glitch dropped");
      rxd = 1'b0; repeat (8) @(negedge clk); rxd = 1'b1;
      repeat (40) @(negedge clk);
      rx_expect(1'b0, "R10 one-vote glitch dropped");
      exp_data = 8'hC3; exp_b9 = 1'b0;
      rx_frame(8'hC3, 1'b0, 1'b1);
      rx_expect(1'b1, "R10 frame after false start");
      rx_clear();

      report();
      $finish;
   end
endmodule